// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is the data-moving half of one DMA channel. Once an outside arbiter has given the channel the bus, each start pulse makes the engine carry out exactly one transfer unit on a simple single-beat memory bus, then report that the unit is finished. Reporting per unit lets the arbiter decide whether to hand the bus back (cycle stealing) or to pulse start again at once (burst).

Software loads four registers through one shared data input and a separate write strobe for each register:
- a 32-bit source address,
- a 32-bit destination address,
- a 24-bit unit counter,
- a control word.

The control word selects:
- the unit size: byte, 16-bit or 32-bit;
- the step for each address: up, down or fixed;
- the mode of operation: dual-address direct, dual-address indirect through a pointer, single-address device-to-memory, or single-address memory-to-device;
- source reload, which rereads the same source on every unit;
- interrupt enable.

The counter decrements once per completed unit. When it reaches zero, the channel stops and sets a done flag, which can drive an interrupt line.

Top module: `dma_xfer_engine`

## Requirements
- R1: The control unit field (bits 1:0) selects 0 = byte, 1 = 16-bit, 2 = 32-bit; 3 is stored as 32-bit. `mem_size` carries the same code on every data cycle. Read data is held right-aligned, with bits above the unit cleared, and is written back as `mem_wdata`.
- R2: The counter decrements by one per completed unit. `done` rises on the unit that takes it from 1 to 0. A loaded value of 0 means 2^24 units, so one unit leaves `done` low.
- R3: Mode 0 (control bits 7:6) performs one read at the source address and then one write at the destination address carrying the read data. Both happen within a single start pulse.
- R4: Mode 2 performs one write cycle at the destination address, and mode 3 performs one read cycle at the source address. In both modes `mem_dack` is high for that cycle, and it is never high in modes 0 and 1.
- R5: Mode 1 first performs a 32-bit read at the source address to fetch a pointer. It then reads the unit at that pointer and writes it to the destination. The source address then steps by 4 regardless of the unit size.
- R6: Control bits 3:2 (source) and 5:4 (destination) each select 0 = fixed, 1 = increment, 2 = decrement. The step is applied after every unit and equals the unit size in bytes (1, 2 or 4).
- R7: With control bit 8 set, the source address returns after each unit to the value last written to the source register.
- R8: `irq` equals `done` AND control bit 9. Writing the counter register clears `done`.
- R9: While `busy` or `done` is high, `start` is ignored. While `busy` is high, register writes are ignored.
- R10: `mem_req` stays high with a stable address and direction until a cycle in which `mem_rdy` is high; that cycle completes the bus access.
- R11: `unit_done` pulses for one cycle, one clock after the last bus access of a unit is accepted. In that same cycle `busy` is already low and the address registers and counter hold their updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_we | input | 1 | Load source address from `wr_data` |
| dst_we | input | 1 | Load destination address from `wr_data` |
| cnt_we | input | 1 | Load unit counter from `wr_data`; clears done |
| ctrl_we | input | 1 | Load control word from `wr_data` |
| wr_data | input | 32 | Shared register write data |
| start | input | 1 | One-cycle request to move one unit |
| busy | output | 1 | A unit is in progress |
| unit_done | output | 1 | One-cycle pulse when a unit finished |
| done | output | 1 | Counter reached zero; channel stopped |
| irq | output | 1 | End-of-transfer interrupt |
| mem_req | output | 1 | Bus access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Bus address |
| mem_size | output | 2 | Access size code, as the unit field |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_rdy | input | 1 | Access completes this cycle |
| mem_dack | output | 1 | Acknowledge strobe for single-address mode |

## Verification
The bench targets the following corner cases, each tied to the faulty behaviour it would expose:

- **Byte transfers with a decrementing, odd source address.** A missing data mask or a wrong step size shows up as wrong write data or a wrong next address.
- **Indirect transfers.** A design that forgets the pointer fetch, forgets to force it to 32 bits, or steps the source by the unit size instead of 4 produces a bus cycle that does not match the scoreboard.
- **Reload and a counter loaded with zero.** These catch a source that drifts on reload, and a `done` that rises too early when the counter starts at zero.
- **Start pulses and register writes while busy, and start after done.** A design that honours any of these shows extra bus traffic or a shifted address.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;

   localparam logic [1:0] STEP_FIX = 2'd0;
   localparam logic [1:0] STEP_INC = 2'd1;
   localparam logic [1:0] STEP_DEC = 2'd2;

   localparam logic [1:0] MD_DUAL = 2'd0;
   localparam logic [1:0] MD_IND  = 2'd1;
   localparam logic [1:0] MD_S2M  = 2'd2;
   localparam logic [1:0] MD_M2S  = 2'd3;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_PTR   = 3'd1,
      PH_READ  = 3'd2,
      PH_WRITE = 3'd3,
      PH_SGL   = 3'd4
   } phase_e;

   typedef struct packed {
      logic       irq_en;
      logic       reload;
      logic [1:0] mode;
      logic [1:0] dstep;
      logic [1:0] sstep;
      logic [1:0] unit;
   } ctrl_t;

   function automatic ctrl_t ctrl_load(input logic [$bits(ctrl_t)-1:0] raw);
      ctrl_t c;
      c = ctrl_t'(raw);
      if (c.unit == 2'd3) c.unit = SZ_LONG;
      return c;
   endfunction

   function automatic logic [2:0] unit_bytes(input logic [1:0] u);
      case (u)
         SZ_BYTE: return 3'd1;
         SZ_WORD: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_xfer_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] cur,
   input  logic [1:0]    dir,
   input  logic [2:0]    bytes,
   output logic [AW-1:0] nxt
);

   always_comb begin
      case (dir)
         STEP_INC: nxt = cur + AW'(bytes);
         STEP_DEC: nxt = cur - AW'(bytes);
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_xfer_pkg::*;
#(
   parameter bit INDIRECT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [1:0] mode,
   input  logic       rdy,
   output phase_e     phase,
   output logic       last_ack
);

   phase_e ph_q, ph_d;

   always_comb begin
      ph_d     = ph_q;
      last_ack = 1'b0;
      case (ph_q)
         PH_IDLE: begin
            if (go) begin
               case (mode)
                  MD_DUAL: ph_d = PH_READ;
                  MD_IND:  ph_d = INDIRECT_EN ? PH_PTR : PH_READ;
                  default: ph_d = PH_SGL;
               endcase
            end
         end
         PH_PTR:  if (rdy) ph_d = PH_READ;
         PH_READ: if (rdy) ph_d = PH_WRITE;
         PH_WRITE, PH_SGL: begin
            if (rdy) begin
               ph_d     = PH_IDLE;
               last_ack = 1'b1;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase = ph_q;

   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_READ && rdy) |=> (ph_q == PH_WRITE)); // R3
   AST_PTR_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PTR && rdy) |=> (ph_q == PH_READ)); // R5

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_xfer_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int CW          = 24,
   parameter bit RELOAD_EN   = 1'b1,
   parameter bit INDIRECT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_we,
   input  logic          dst_we,
   input  logic          cnt_we,
   input  logic          ctrl_we,
   input  logic [DW-1:0] wr_data,
   input  logic          start,
   output logic          busy,
   output logic          unit_done,
   output logic          done,
   output logic          irq,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rdy,
   output logic          mem_dack
);

   localparam int CTRL_W = $bits(ctrl_t);

   if (DW < 32) begin : g_chk_dw
      $error("dma_xfer_engine: DW must hold a 32-bit unit");
   end
   if (AW > DW) begin : g_chk_aw
      $error("dma_xfer_engine: AW must fit in wr_data and pointer reads");
   end
   if (CW < 1 || CW > DW) begin : g_chk_cw
      $error("dma_xfer_engine: CW out of range");
   end

   ctrl_t           ctrl_q;
   logic [AW-1:0]   src_q, dst_q, src_nxt, dst_nxt, src_home, ptr_q;
   logic [CW-1:0]   cnt_q;
   logic [DW-1:0]   buf_q, unit_mask;
   logic            done_q, unit_done_q;
   phase_e          phase;
   logic            last_ack, busy_w, go, ind_sel;
   logic [2:0]      ubytes, sbytes;

   assign busy_w  = (phase != PH_IDLE);
   assign go      = start && !busy_w && !done_q;
   assign ind_sel = INDIRECT_EN && (ctrl_q.mode == MD_IND);
   assign ubytes  = unit_bytes(ctrl_q.unit);
   assign sbytes  = ind_sel ? 3'd4 : ubytes;

   always_comb begin
      case (ctrl_q.unit)
         SZ_BYTE: unit_mask = DW'(8'hFF);
         SZ_WORD: unit_mask = DW'(16'hFFFF);
         default: unit_mask = '1;
      endcase
   end

   dma_xfer_seq #(.INDIRECT_EN(INDIRECT_EN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .mode     (ctrl_q.mode),
      .rdy      (mem_rdy),
      .phase    (phase),
      .last_ack (last_ack)
   );

   dma_addr_step #(.AW(AW)) u_src_step (
      .cur (src_q), .dir (ctrl_q.sstep), .bytes (sbytes), .nxt (src_nxt)
   );

   dma_addr_step #(.AW(AW)) u_dst_step (
      .cur (dst_q), .dir (ctrl_q.dstep), .bytes (ubytes), .nxt (dst_nxt)
   );

   // Reload shadow: a real register only when the option is built in.
   if (RELOAD_EN) begin : g_reload
      logic [AW-1:0] home_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  home_q <= '0;
         else if (src_we && !busy_w)  home_q <= wr_data[AW-1:0];
      end
      assign src_home = home_q;
   end else begin : g_no_reload
      assign src_home = src_nxt;
   end

   // Pointer register for indirect fetches.
   if (INDIRECT_EN) begin : g_ind
      logic [AW-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              p_q <= '0;
         else if (phase == PH_PTR && mem_rdy)     p_q <= mem_rdata[AW-1:0];
      end
      assign ptr_q = p_q;
   end else begin : g_no_ind
      assign ptr_q = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q       <= '0;
         dst_q       <= '0;
         cnt_q       <= '0;
         ctrl_q      <= '0;
         buf_q       <= '0;
         done_q      <= 1'b0;
         unit_done_q <= 1'b0;
      end else begin
         unit_done_q <= last_ack;
         if (!busy_w) begin
            if (src_we)  src_q  <= wr_data[AW-1:0];
            if (dst_we)  dst_q  <= wr_data[AW-1:0];
            if (ctrl_we) ctrl_q <= ctrl_load(wr_data[CTRL_W-1:0]);
            if (cnt_we) begin
               cnt_q  <= wr_data[CW-1:0];
               done_q <= 1'b0;
            end
         end
         if (phase == PH_READ && mem_rdy) buf_q <= mem_rdata & unit_mask;
         if (last_ack) begin
            src_q  <= ctrl_q.reload ? src_home : src_nxt;
            dst_q  <= dst_nxt;
            cnt_q  <= cnt_q - 1'b1;
            done_q <= (cnt_q == CW'(1));
         end
      end
   end

   always_comb begin
      case (phase)
         PH_PTR:   mem_addr = src_q;
         PH_READ:  mem_addr = ind_sel ? ptr_q : src_q;
         PH_WRITE: mem_addr = dst_q;
         PH_SGL:   mem_addr = (ctrl_q.mode == MD_S2M) ? dst_q : src_q;
         default:  mem_addr = '0;
      endcase
   end

   assign mem_req   = busy_w;
   assign mem_dack  = (phase == PH_SGL);
   assign mem_we    = (phase == PH_WRITE) || (phase == PH_SGL && ctrl_q.mode == MD_S2M);
   assign mem_size  = (phase == PH_PTR) ? SZ_LONG : ctrl_q.unit;
   assign mem_wdata = buf_q;
   assign busy      = busy_w;
   assign unit_done = unit_done_q;
   assign done      = done_q;
   assign irq       = done_q && ctrl_q.irq_en;

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
   AST_ACK_SINGLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dack |-> ctrl_q.mode[1]); // R4
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      unit_done |-> (cnt_q == CW'($past(cnt_q) - 1'b1))); // R2
   AST_NO_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy && start) |=> !mem_req); // R9
   AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done); // R8
   AST_IDLE_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      unit_done |-> !busy); // R11

endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_we = 0, dst_we = 0, cnt_we = 0, ctrl_we = 0, start = 0;
   logic [31:0] wr_data = '0;
   logic        busy, unit_done, done, irq, mem_req, mem_we, mem_dack;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_rdy = 1'b0;
   logic [1:0]  mem_size;

   int n_total = 0;
   int n_fail  = 0;
   bit slow    = 0;
   bit waited  = 0;

   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [1:0]  size;
      bit          dack;
      bit          chkd;
      logic [31:0] wdata;
      string       req;
   } cyc_t;
   cyc_t exp_q[$];

   logic [31:0] b_src, b_dst, b_home;
   logic [1:0]  b_unit, b_ss, b_ds, b_mode;
   bit          b_rl;

   always #5 clk = ~clk;

   dma_xfer_engine uut (
      .clk(clk), .rst_n(rst_n), .src_we(src_we), .dst_we(dst_we), .cnt_we(cnt_we),
      .ctrl_we(ctrl_we), .wr_data(wr_data), .start(start), .busy(busy),
      .unit_done(unit_done), .done(done), .irq(irq), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .mem_dack(mem_dack)
   );

   function automatic logic [31:0] fm(input logic [31:0] a);
      return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] msk(input logic [1:0] u);
      return (u == 2'd0) ? 32'hFF : (u == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] stp(input logic [31:0] a, input logic [1:0] d, input int b);
      return (d == 2'd1) ? a + b : (d == 2'd2) ? a - b : a;
   endfunction

   function automatic logic [31:0] cfg(input logic [1:0] u, ss, ds, md, input bit rl, ie);
      return {22'd0, ie, rl, md, ds, ss, u};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Responder and monitor: decides rdy at the falling edge and scores the
   // access that the next rising edge will accept.
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            if (slow && !waited) begin
               mem_rdy = 1'b0;
               waited  = 1'b1;
            end else begin
               mem_rdy   = 1'b1;
               waited    = 1'b0;
               mem_rdata = fm(mem_addr);
               if (exp_q.size() == 0) begin
                  chk(0, "R9", "unexpected bus access addr", mem_addr, 32'h0);
               end else begin
                  cyc_t e;
                  bit ok;
                  e  = exp_q.pop_front();
                  ok = (mem_we == e.we) && (mem_addr == e.addr) && (mem_size == e.size) &&
                       (mem_dack == e.dack) && (!e.chkd || mem_wdata == e.wdata);
                  chk(ok, e.req, $sformatf("access we%0b sz%0d dack%0b wd %h / addr",
                      mem_we, mem_size, mem_dack, mem_wdata), mem_addr, e.addr);
                  if (e.chkd)
                     chk(mem_wdata == e.wdata, "R1", "write data", mem_wdata, e.wdata);
               end
            end
         end else begin
            mem_rdy = 1'b0;
            waited  = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "R11", "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   task automatic wr(input int which, input logic [31:0] v);
      @(negedge clk);
      wr_data = v;
      case (which)
         0: src_we = 1;
         1: dst_we = 1;
         2: cnt_we = 1;
         default: ctrl_we = 1;
      endcase
      @(negedge clk);
      {src_we, dst_we, cnt_we, ctrl_we} = '0;
   endtask

   task automatic setup(input logic [31:0] s, d, c, input logic [1:0] u, ss, ds, md,
                        input bit rl, ie);
      wr(0, s); wr(1, d); wr(2, c); wr(3, cfg(u, ss, ds, md, rl, ie));
      b_src = s; b_home = s; b_dst = d; b_unit = u; b_ss = ss; b_ds = ds;
      b_mode = md; b_rl = rl;
   endtask

   task automatic push_unit(input string r);
      logic [31:0] p;
      int sb;
      sb = (b_unit == 2'd0) ? 1 : (b_unit == 2'd1) ? 2 : 4;
      case (b_mode)
         2'd0: begin
            exp_q.push_back('{0, b_src, b_unit, 0, 0, 32'h0, r});
            exp_q.push_back('{1, b_dst, b_unit, 0, 1, fm(b_src) & msk(b_unit), r});
         end
         2'd1: begin
            p = fm(b_src);
            exp_q.push_back('{0, b_src, 2'd2, 0, 0, 32'h0, r});
            exp_q.push_back('{0, p, b_unit, 0, 0, 32'h0, r});
            exp_q.push_back('{1, b_dst, b_unit, 0, 1, fm(p) & msk(b_unit), r});
         end
         2'd2: exp_q.push_back('{1, b_dst, b_unit, 1, 0, 32'h0, r});
         default: exp_q.push_back('{0, b_src, b_unit, 1, 0, 32'h0, r});
      endcase
      b_src = b_rl ? b_home : stp(b_src, b_ss, (b_mode == 2'd1) ? 4 : sb);
      b_dst = stp(b_dst, b_ds, sb);
   endtask

   task automatic run_unit();
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      while (!unit_done) @(negedge clk);
      chk(!busy, "R11", "busy low at unit_done", {31'd0, busy}, 32'h0);
   endtask

   task automatic quiet(input string r);
      bit seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (mem_req) seen = 1;
      end
      chk(!seen, r, "no bus traffic", {31'd0, seen}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !irq && !mem_req && !unit_done, "R11", "reset state",
          {27'd0, busy, done, irq, mem_req, unit_done}, 32'h0);

      // Dual direct, 32-bit, both up, 3 units, interrupt on
      setup(32'h1000, 32'h2000, 3, 2'd2, 2'd1, 2'd1, 2'd0, 0, 1);
      for (int i = 0; i < 3; i++) begin
         push_unit("R3");
         run_unit();
         chk(done == (i == 2), "R2", "done after unit", {31'd0, done}, {31'd0, (i == 2)});
      end
      chk(irq, "R8", "irq with done and enable", {31'd0, irq}, 32'h1);

      // Start after done is ignored
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      quiet("R9");

      // Counter write clears done; byte, source down, destination fixed, wait states
      slow = 1;
      setup(32'h3003, 32'h4000, 2, 2'd0, 2'd2, 2'd0, 2'd0, 0, 1);
      chk(!done && !irq, "R8", "counter write clears done", {30'd0, done, irq}, 32'h0);
      for (int i = 0; i < 2; i++) begin
         push_unit("R6");
         run_unit();
      end
      chk(done, "R2", "done after two byte units", {31'd0, done}, 32'h1);

      // Reload, 16-bit
      slow = 0;
      setup(32'h5000, 32'h6000, 3, 2'd1, 2'd1, 2'd1, 2'd0, 1, 0);
      for (int i = 0; i < 3; i++) begin
         push_unit("R7");
         run_unit();
      end
      chk(done && !irq, "R8", "irq masked when disabled", {30'd0, done, irq}, 32'h2);

      // Indirect, 16-bit, destination down
      setup(32'h7000, 32'h8000, 2, 2'd1, 2'd1, 2'd2, 2'd1, 0, 0);
      for (int i = 0; i < 2; i++) begin
         push_unit("R5");
         run_unit();
      end

      // Single address both directions
      setup(32'h0, 32'h9000, 1, 2'd0, 2'd0, 2'd1, 2'd2, 0, 0);
      push_unit("R4");
      run_unit();
      chk(done, "R2", "count of one ends run", {31'd0, done}, 32'h1);
      setup(32'hA000, 32'h0, 1, 2'd3, 2'd1, 2'd0, 2'd3, 0, 0);
      b_unit = 2'd2; // code 3 is held as 32-bit
      push_unit("R1");
      run_unit();

      // Start and register write during a unit are ignored
      slow = 1;
      setup(32'hB000, 32'hC000, 5, 2'd2, 2'd1, 2'd1, 2'd0, 0, 0);
      push_unit("R9");
      @(negedge clk); start = 1;
      @(negedge clk); start = 1; src_we = 1; wr_data = 32'hDEAD_0000;
      @(negedge clk); start = 0; src_we = 0;
      while (!unit_done) @(negedge clk);
      quiet("R9");
      push_unit("R9");
      run_unit();

      // Counter loaded with zero means 2^24 units
      slow = 0;
      setup(32'hD000, 32'hE000, 0, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0);
      push_unit("R2");
      run_unit();
      chk(!done, "R2", "zero count not done after one unit", {31'd0, done}, 32'h0);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 32'h0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule